// File: doc/BRIEF.md
# Message-Granular Receive FIFO

This block is the receive store of a bus controller. It holds complete received messages in a circular byte RAM and manages them whole, never byte by byte. A frame receiver feeds the bytes of one accepted message through a write port. The first byte is a frame-information byte. The receiver then ends the message with a commit when the frame turns out valid, or with a discard when the frame fails with an error. Room for the whole message is reserved when its first byte arrives. A message that does not fit is dropped entirely, and it is reported as an overrun only if its frame later commits.

The host sees the oldest stored message through a read window placed at a base pointer. A read offset selects a byte relative to that base. A release command frees the oldest message and moves the base past it. The block provides a receive-available status, a message count, an overrun status and two interrupt flags. The interrupt flags are a receive interrupt and an overrun interrupt, and each has its own enable.

The frame-information byte defines the message length:
- Bit 7 selects a 5-byte extended descriptor. When it is clear, the descriptor is 3 bytes.
- Bit 6 marks a remote frame, which has no data bytes.
- Bits 3:0 hold the data length code.

Top module: `rxf_msg_fifo`

## Requirements
- R1: A stored message occupies its descriptor followed by its data bytes, in arrival order, at consecutive addresses modulo DEPTH. `rd_data` shows, in the same cycle, the byte at `rx_base + rd_ofs` (modulo DEPTH). This holds also when a message straddles the end of the RAM.
- R2: The length of a message is the descriptor length plus the data length. The descriptor is 5 bytes when bit 7 of the first byte is 1 and 3 bytes otherwise. The data length is 0 when bit 6 is 1; otherwise it is bits 3:0, capped at 8. Bytes delivered beyond that length are not stored.
- R3: A message is admitted only when its full length fits in the free space at the moment its first byte arrives. Otherwise none of its bytes are stored, and its commit leaves `msg_count` unchanged.
- R4: `overrun` sets only when a dropped message is committed. A dropped message that is discarded leaves `overrun` at 0. `ovr_irq` sets together with a 0-to-1 change of `overrun` when `ovr_ie` is 1. It does not set while `overrun` is already 1.
- R5: A `clr_ovr` pulse clears `overrun`, including when it is given in the same cycle as `release_msg`.
- R6: A discard removes all bytes of the partly written message. Stored messages and `msg_count` are unchanged.
- R7: A commit of an admitted message increments `msg_count` and sets `rx_avail` at the same clock edge. `rx_irq` sets when `rx_avail` goes from 0 to 1 and `rx_ie` is 1.
- R8: `release_msg` advances `rx_base` by the head message's length modulo DEPTH and decrements `msg_count`. `rx_avail` drops for one cycle. If messages remain, it returns to 1 in the next cycle and sets `rx_irq` again; otherwise it stays 0.
- R9: An `irq_rd` pulse clears `rx_irq` and `ovr_irq`.
- R10: A `soft_rst` pulse empties the store and clears all status and interrupt flags, but keeps `rx_base`. The next message is written at that base. A hardware reset (`rst_n` low) returns `rx_base` to 0.
- R11: `release_msg` while `msg_count` is 0 changes neither `rx_base` nor `msg_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Software or bus-off reset pulse |
| wr_valid | input | 1 | A message byte is present on `wr_byte` |
| wr_byte | input | 8 | Message byte; the first byte of a message is the frame-information byte |
| wr_commit | input | 1 | The current message's frame is valid |
| wr_discard | input | 1 | The current message's frame failed |
| rd_ofs | input | AW | Read offset from the base, where AW = log2(DEPTH) |
| rd_data | output | 8 | Byte at base plus offset |
| rx_base | output | AW | Address of the oldest message |
| release_msg | input | 1 | Free the oldest message |
| clr_ovr | input | 1 | Clear the overrun status |
| irq_rd | input | 1 | Interrupt flags read and cleared |
| rx_ie | input | 1 | Receive interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| rx_avail | output | 1 | At least one message is readable |
| msg_count | output | AW+1 | Number of stored messages |
| overrun | output | 1 | A message was lost for lack of space |
| rx_irq | output | 1 | Receive interrupt flag |
| ovr_irq | output | 1 | Overrun interrupt flag |

## Verification
The bench builds the block with DEPTH set to 32 and a combinational read window. With that size, a handful of short messages is enough to exhaust the free space, so the overflow path is reached with both a discard and a commit. The same messages also make one stored message straddle the end of the RAM, so reads, release arithmetic and admission across the wrap are all exercised. The 64-byte default keeps the same pointer logic, only one bit wider.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   localparam int STD_DESC_LEN = 3;
   localparam int EXT_DESC_LEN = 5;
   localparam int MAX_DATA_LEN = 8;
   localparam int LEN_W        = 4;

   // Frame-information byte fields
   typedef struct packed {
      logic       ext;
      logic       rtr;
      logic [1:0] rsvd;
      logic [3:0] dlc;
   } rxf_info_t;

   function automatic logic [LEN_W-1:0] rxf_msg_len(input logic [7:0] b);
      rxf_info_t        inf;
      logic [LEN_W-1:0] dlen;
      logic [LEN_W-1:0] dsc;
      inf  = rxf_info_t'(b);
      if (inf.rtr)
         dlen = '0;
      else if (inf.dlc > LEN_W'(MAX_DATA_LEN))
         dlen = LEN_W'(MAX_DATA_LEN);
      else
         dlen = inf.dlc;
      dsc = inf.ext ? LEN_W'(EXT_DESC_LEN) : LEN_W'(STD_DESC_LEN);
      return dsc + dlen;
   endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int DEPTH  = 64,
   parameter int AW     = 6,
   parameter bit REG_RD = 1'b0
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] rd_ofs,
   output logic [7:0]    rd_data,
   output logic [7:0]    head_byte
);

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] raddr;

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   assign raddr     = base + rd_ofs;
   assign head_byte = mem[base];

   generate
      if (REG_RD) begin : g_rd_reg
         logic [7:0] rd_q;
         always_ff @(posedge clk) begin
            rd_q <= mem[raddr];
         end
         assign rd_data = rd_q;
      end else begin : g_rd_comb
         assign rd_data = mem[raddr];
      end
   endgenerate

endmodule

// File: rtl/rxf_ptrs.sv
module rxf_ptrs
   import rxf_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int AW    = 6,
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          wr_valid,
   input  logic [7:0]    wr_byte,
   input  logic          wr_commit,
   input  logic          wr_discard,
   input  logic          release_i,
   input  logic [7:0]    head_byte,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [7:0]    wdata,
   output logic [AW-1:0] base,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] cnt_d,
   output logic          rel_ok,
   output logic          ovr_evt
);

   logic [AW-1:0]    base_q, wcur_q, wtent_q;
   logic [CW-1:0]    used_q, used_d, free_w;
   logic             in_msg_q, drop_q;
   logic [LEN_W-1:0] need_q, got_q;
   logic [LEN_W-1:0] new_len, rel_len;
   logic             busy_end, first_b, more_b, fits, commit_ok;

   assign busy_end  = wr_commit || wr_discard || soft_rst;
   assign first_b   = wr_valid && !in_msg_q && !busy_end;
   assign more_b    = wr_valid && in_msg_q && !drop_q && (got_q < need_q) && !busy_end;
   assign new_len   = rxf_msg_len(wr_byte);
   assign rel_len   = rxf_msg_len(head_byte);
   assign free_w    = CW'(DEPTH) - used_q;
   assign fits      = (CW'(new_len) <= free_w);
   assign commit_ok = wr_commit && in_msg_q && !drop_q && !soft_rst;
   assign ovr_evt   = wr_commit && in_msg_q && drop_q && !soft_rst;
   assign rel_ok    = release_i && (cnt_q != '0) && !soft_rst;

   assign we    = (first_b && fits) || more_b;
   assign waddr = first_b ? wcur_q : wtent_q;
   assign wdata = wr_byte;
   assign base  = base_q;

   always_comb begin
      cnt_d  = cnt_q;
      used_d = used_q;
      if (commit_ok) begin
         cnt_d  = cnt_d + 1'b1;
         used_d = used_d + CW'(need_q);
      end
      if (rel_ok) begin
         cnt_d  = cnt_d - 1'b1;
         used_d = used_d - CW'(rel_len);
      end
      if (soft_rst) begin
         cnt_d  = '0;
         used_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         wcur_q   <= '0;
         wtent_q  <= '0;
         used_q   <= '0;
         cnt_q    <= '0;
         in_msg_q <= 1'b0;
         drop_q   <= 1'b0;
         need_q   <= '0;
         got_q    <= '0;
      end else begin
         used_q <= used_d;
         cnt_q  <= cnt_d;
         if (soft_rst) begin
            wcur_q   <= base_q;
            wtent_q  <= base_q;
            in_msg_q <= 1'b0;
            drop_q   <= 1'b0;
         end else begin
            if (rel_ok)
               base_q <= base_q + AW'(rel_len);
            if (wr_commit && in_msg_q) begin
               in_msg_q <= 1'b0;
               drop_q   <= 1'b0;
               if (!drop_q)
                  wcur_q <= wtent_q;
            end else if (wr_discard && in_msg_q) begin
               in_msg_q <= 1'b0;
               drop_q   <= 1'b0;
               wtent_q  <= wcur_q;
            end else if (first_b) begin
               in_msg_q <= 1'b1;
               drop_q   <= !fits;
               need_q   <= new_len;
               got_q    <= LEN_W'(1);
               if (fits)
                  wtent_q <= wcur_q + 1'b1;
            end else if (more_b) begin
               wtent_q <= wtent_q + 1'b1;
               got_q   <= got_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic [CW-1:0] cnt_d,
   input  logic          rel_ok,
   input  logic          ovr_evt,
   input  logic          clr_ovr,
   input  logic          irq_rd,
   input  logic          rx_ie,
   input  logic          ovr_ie,
   output logic          rx_avail,
   output logic          overrun,
   output logic          rx_irq,
   output logic          ovr_irq
);

   logic rbs_q, rbs_d, ovr_q, rxi_q, ovi_q;
   logic rx_set, ovr_first, ovi_set;

   assign rbs_d     = (cnt_d != '0) && !rel_ok;
   assign rx_set    = rbs_d && !rbs_q && rx_ie;
   assign ovr_first = ovr_evt && !ovr_q;
   assign ovi_set   = ovr_first && ovr_ie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbs_q <= 1'b0;
         ovr_q <= 1'b0;
         rxi_q <= 1'b0;
         ovi_q <= 1'b0;
      end else if (soft_rst) begin
         rbs_q <= 1'b0;
         ovr_q <= 1'b0;
         rxi_q <= 1'b0;
         ovi_q <= 1'b0;
      end else begin
         rbs_q <= rbs_d;
         if (ovr_evt)
            ovr_q <= 1'b1;
         else if (clr_ovr)
            ovr_q <= 1'b0;
         if (rx_set)
            rxi_q <= 1'b1;
         else if (irq_rd)
            rxi_q <= 1'b0;
         if (ovi_set)
            ovi_q <= 1'b1;
         else if (irq_rd)
            ovi_q <= 1'b0;
      end
   end

   assign rx_avail = rbs_q;
   assign overrun  = ovr_q;
   assign rx_irq   = rxi_q;
   assign ovr_irq  = ovi_q;

endmodule

// File: rtl/rxf_msg_fifo.sv
module rxf_msg_fifo #(
   parameter int DEPTH  = 64,
   parameter bit REG_RD = 1'b0,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          wr_valid,
   input  logic [7:0]    wr_byte,
   input  logic          wr_commit,
   input  logic          wr_discard,
   input  logic [AW-1:0] rd_ofs,
   output logic [7:0]    rd_data,
   output logic [AW-1:0] rx_base,
   input  logic          release_msg,
   input  logic          clr_ovr,
   input  logic          irq_rd,
   input  logic          rx_ie,
   input  logic          ovr_ie,
   output logic          rx_avail,
   output logic [CW-1:0] msg_count,
   output logic          overrun,
   output logic          rx_irq,
   output logic          ovr_irq
);

   generate
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
         $error("rxf_msg_fifo: DEPTH must be a power of two");
      end
      if (DEPTH < 16) begin : g_bad_size
         $error("rxf_msg_fifo: DEPTH must hold at least one longest message");
      end
   endgenerate

   logic          we, rel_ok, ovr_evt;
   logic [AW-1:0] waddr, base;
   logic [7:0]    wdata, head_byte;
   logic [CW-1:0] cnt_q, cnt_d;

   rxf_store #(.DEPTH(DEPTH), .AW(AW), .REG_RD(REG_RD)) u_store (
      .clk       (clk),
      .we        (we),
      .waddr     (waddr),
      .wdata     (wdata),
      .base      (base),
      .rd_ofs    (rd_ofs),
      .rd_data   (rd_data),
      .head_byte (head_byte)
   );

   rxf_ptrs #(.DEPTH(DEPTH), .AW(AW)) u_ptrs (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .wr_valid   (wr_valid),
      .wr_byte    (wr_byte),
      .wr_commit  (wr_commit),
      .wr_discard (wr_discard),
      .release_i  (release_msg),
      .head_byte  (head_byte),
      .we         (we),
      .waddr      (waddr),
      .wdata      (wdata),
      .base       (base),
      .cnt_q      (cnt_q),
      .cnt_d      (cnt_d),
      .rel_ok     (rel_ok),
      .ovr_evt    (ovr_evt)
   );

   rxf_flags #(.CW(CW)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .cnt_d    (cnt_d),
      .rel_ok   (rel_ok),
      .ovr_evt  (ovr_evt),
      .clr_ovr  (clr_ovr),
      .irq_rd   (irq_rd),
      .rx_ie    (rx_ie),
      .ovr_ie   (ovr_ie),
      .rx_avail (rx_avail),
      .overrun  (overrun),
      .rx_irq   (rx_irq),
      .ovr_irq  (ovr_irq)
   );

   assign rx_base   = base;
   assign msg_count = cnt_q;

endmodule

// File: rtl/rxf_msg_fifo_chk.sv
module rxf_msg_fifo_chk #(
   parameter int AW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          soft_rst,
   input logic          wr_commit,
   input logic          release_msg,
   input logic          clr_ovr,
   input logic          rx_avail,
   input logic [AW:0]   msg_count,
   input logic          overrun,
   input logic          ovr_irq,
   input logic [AW-1:0] rx_base
);

   // R7 / R8: a readable message implies a nonzero count
   p_avail_needs_msg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_avail |-> (msg_count != '0));

   // R8: release decrements the count
   p_release_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (release_msg && msg_count != '0 && !wr_commit && !soft_rst)
      |=> (int'(msg_count) == int'($past(msg_count)) - 1));

   // R8: releasing the last message leaves nothing available
   p_last_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (release_msg && msg_count == 1 && !wr_commit && !soft_rst) |=> !rx_avail);

   // R4 / R5: overrun changes only on a commit, a clear or a soft reset
   p_ovr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_commit && !clr_ovr && !soft_rst) |=> $stable(overrun));

   // R4: the overrun interrupt only rises with the status
   p_ovr_irq_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_irq) |-> $rose(overrun));

   // R10 / R11: base moves only on a release
   p_base_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !release_msg |=> $stable(rx_base));

endmodule

bind rxf_msg_fifo rxf_msg_fifo_chk #(.AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .soft_rst    (soft_rst),
   .wr_commit   (wr_commit),
   .release_msg (release_msg),
   .clr_ovr     (clr_ovr),
   .rx_avail    (rx_avail),
   .msg_count   (msg_count),
   .overrun     (overrun),
   .ovr_irq     (ovr_irq),
   .rx_base     (rx_base)
);

// File: tb/rxf_msg_fifo_tb_top.sv
`timescale 1ns/1ps
module rxf_msg_fifo_tb_top;

   localparam int DEPTH = 32;
   localparam int AW    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          soft_rst = 1'b0;
   logic          wr_valid = 1'b0;
   logic [7:0]    wr_byte = '0;
   logic          wr_commit = 1'b0;
   logic          wr_discard = 1'b0;
   logic [AW-1:0] rd_ofs = '0;
   logic [7:0]    rd_data;
   logic [AW-1:0] rx_base;
   logic          release_msg = 1'b0;
   logic          clr_ovr = 1'b0;
   logic          irq_rd = 1'b0;
   logic          rx_ie = 1'b1;
   logic          ovr_ie = 1'b1;
   logic          rx_avail;
   logic [AW:0]   msg_count;
   logic          overrun;
   logic          rx_irq;
   logic          ovr_irq;

   always #2.5 clk = ~clk;

   rxf_msg_fifo #(.DEPTH(DEPTH), .REG_RD(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_commit(wr_commit),
      .wr_discard(wr_discard), .rd_ofs(rd_ofs), .rd_data(rd_data),
      .rx_base(rx_base), .release_msg(release_msg), .clr_ovr(clr_ovr),
      .irq_rd(irq_rd), .rx_ie(rx_ie), .ovr_ie(ovr_ie),
      .rx_avail(rx_avail), .msg_count(msg_count), .overrun(overrun),
      .rx_irq(rx_irq), .ovr_irq(ovr_irq)
   );

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // scoreboard
   logic [7:0] exp_bytes[$];
   int         exp_lens[$];
   int         exp_used = 0;
   int         exp_cnt  = 0;
   int         exp_base = 0;

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int mlen(input logic [7:0] b);
      int d;
      d = b[6] ? 0 : ((int'(b[3:0]) > 8) ? 8 : int'(b[3:0]));
      return (b[7] ? 5 : 3) + d;
   endfunction

   // driver: stop_after < 0 sends the whole message plus extra bytes
   task automatic send_msg(input logic [7:0] info, input int extra,
                           input logic [7:0] seed, input int stop_after,
                           input bit do_commit);
      int len, nsend;
      bit fits;
      logic [7:0] q[$];
      logic [7:0] b;
      len   = mlen(info);
      nsend = (stop_after >= 0) ? stop_after : len + extra;
      fits  = (len <= DEPTH - exp_used);
      for (int i = 0; i < nsend; i++) begin
         b = (i == 0) ? info : 8'(seed + i);
         @(negedge clk);
         wr_valid = 1'b1;
         wr_byte  = b;
         if (i < len) q.push_back(b);
      end
      @(negedge clk);
      wr_valid = 1'b0;
      if (do_commit) wr_commit = 1'b1;
      else           wr_discard = 1'b1;
      @(negedge clk);
      wr_commit  = 1'b0;
      wr_discard = 1'b0;
      if (do_commit && fits) begin
         foreach (q[i]) exp_bytes.push_back(q[i]);
         exp_lens.push_back(len);
         exp_used += len;
         exp_cnt++;
      end
   endtask

   // monitor: compare the head window with the scoreboard front
   task automatic check_head(input string req);
      int len, bad_i, bad_a, bad_e;
      len   = exp_lens[0];
      bad_i = -1;
      bad_a = 0;
      bad_e = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rd_ofs = AW'(i);
         #1;
         if (bad_i < 0 && rd_data !== exp_bytes[i]) begin
            bad_i = i;
            bad_a = int'(rd_data);
            bad_e = int'(exp_bytes[i]);
         end
      end
      chk({req, " head bytes"}, bad_a, bad_e);
   endtask

   task automatic release_head(input bit with_clr);
      int len;
      @(negedge clk);
      release_msg = 1'b1;
      clr_ovr     = with_clr;
      @(negedge clk);
      release_msg = 1'b0;
      clr_ovr     = 1'b0;
      if (exp_cnt > 0) begin
         len = exp_lens.pop_front();
         for (int i = 0; i < len; i++) void'(exp_bytes.pop_front());
         exp_used -= len;
         exp_cnt--;
         exp_base = (exp_base + len) % DEPTH;
      end
   endtask

   task automatic pulse_irq_rd();
      @(negedge clk);
      irq_rd = 1'b1;
      @(negedge clk);
      irq_rd = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R10)
      chk("R10 reset count", int'(msg_count), 0);
      chk("R10 reset avail", int'(rx_avail), 0);
      chk("R10 reset overrun", int'(overrun), 0);
      chk("R10 reset base", int'(rx_base), 0);
      chk("R9 reset irqs", int'(rx_irq) + int'(ovr_irq), 0);

      // A: standard, dlc 3 -> 6 bytes (R7)
      send_msg(8'h03, 0, 8'h10, -1, 1'b1);
      chk("R7 count after commit", int'(msg_count), 1);
      chk("R7 avail after commit", int'(rx_avail), 1);
      chk("R7 rx_irq after commit", int'(rx_irq), 1);
      pulse_irq_rd();
      chk("R9 rx_irq cleared", int'(rx_irq), 0);

      // B: extended, dlc 8 -> 13 bytes; no new irq while avail stays high (R7)
      send_msg(8'h88, 0, 8'h40, -1, 1'b1);
      chk("R7 count two", int'(msg_count), 2);
      chk("R7 no irq without rise", int'(rx_irq), 0);
      check_head("R1 standard msg");

      // release A: dip then return (R8)
      release_head(1'b0);
      chk("R8 avail dips", int'(rx_avail), 0);
      chk("R8 base advance", int'(rx_base), exp_base);
      chk("R8 count dec", int'(msg_count), exp_cnt);
      @(negedge clk);
      chk("R8 avail returns", int'(rx_avail), 1);
      chk("R8 rx_irq again", int'(rx_irq), 1);
      check_head("R1 extended msg");

      // C: dlc 15 capped to 8 -> 11 bytes, 2 extra bytes ignored (R2)
      send_msg(8'h0F, 2, 8'h70, -1, 1'b1);
      // D: remote frame -> 3 bytes, straddles the wrap (R2, R1)
      send_msg(8'h48, 1, 8'hA0, -1, 1'b1);
      chk("R2 count four-minus-one", int'(msg_count), 3);

      // E: fits but discarded part-way (R6)
      send_msg(8'h01, 0, 8'hC0, 2, 1'b0);
      chk("R6 count after discard", int'(msg_count), 3);

      // F: does not fit, discarded -> no overrun (R4)
      send_msg(8'h08, 0, 8'hD0, -1, 1'b0);
      chk("R4 no overrun on error", int'(overrun), 0);

      // G: does not fit, committed -> overrun (R4, R3)
      send_msg(8'h08, 0, 8'hE0, -1, 1'b1);
      chk("R4 overrun set", int'(overrun), 1);
      chk("R4 ovr_irq set", int'(ovr_irq), 1);
      chk("R3 count unchanged", int'(msg_count), 3);
      pulse_irq_rd();
      chk("R9 ovr_irq cleared", int'(ovr_irq), 0);

      // H: second overflow while status set -> no interrupt (R4)
      send_msg(8'h08, 0, 8'hF0, -1, 1'b1);
      chk("R4 no repeat ovr_irq", int'(ovr_irq), 0);
      chk("R4 overrun held", int'(overrun), 1);

      // release B together with clear-overrun (R5)
      release_head(1'b1);
      chk("R5 overrun cleared", int'(overrun), 0);
      chk("R8 base after B", int'(rx_base), exp_base);
      check_head("R2 capped msg");
      release_head(1'b0);
      chk("R8 base after C", int'(rx_base), exp_base);
      check_head("R1 wrapped remote msg");

      // release last message: stays low (R8)
      release_head(1'b0);
      @(negedge clk);
      chk("R8 avail stays low", int'(rx_avail), 0);
      chk("R8 count zero", int'(msg_count), 0);
      chk("R8 base after D", int'(rx_base), exp_base);

      // release with empty store (R11)
      release_head(1'b0);
      chk("R11 base unchanged", int'(rx_base), exp_base);
      chk("R11 count unchanged", int'(msg_count), 0);

      // receive interrupt disabled (R7)
      pulse_irq_rd();
      rx_ie = 1'b0;
      send_msg(8'h00, 0, 8'h20, -1, 1'b1);
      chk("R7 avail with ie off", int'(rx_avail), 1);
      chk("R7 no irq with ie off", int'(rx_irq), 0);
      rx_ie = 1'b1;

      // software reset keeps base (R10)
      @(negedge clk);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      exp_bytes.delete();
      exp_lens.delete();
      exp_used = 0;
      exp_cnt  = 0;
      chk("R10 soft count", int'(msg_count), 0);
      chk("R10 soft avail", int'(rx_avail), 0);
      chk("R10 soft base kept", int'(rx_base), exp_base);
      send_msg(8'h01, 0, 8'h55, -1, 1'b1);
      chk("R10 count after soft", int'(msg_count), 1);
      check_head("R10 msg at kept base");

      // hardware reset returns base to 0 (R10)
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 hw base zero", int'(rx_base), 0);
      chk("R10 hw count zero", int'(msg_count), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule